// File: doc/BRIEF.md
# SCSI Host Adapter Command and Interrupt Unit

This block is the register-side control core of a simple SCSI host adapter. Software writes command bytes and transfer counts over a byte-wide register bus. The block decodes each command into a fixed update of four registers: the status register, the interrupt-reason register, the sequence-step register and the FIFO-flags register. It drives one level interrupt line, which always follows the status register's interrupt bit. Reading the interrupt-reason register acknowledges the interrupt.

The bus phases, selection timing, data path and DMA engine live outside this block. When an external sequencer finishes a phase, it reports this with a single-cycle pulse on `phase_done`. A synchronous hard reset and a soft-reset command both return every register to its initial image.

Register map (4-bit address): 0 count low, 1 count middle, 2 count high (read-only chip identifier), 3 command (write), 4 status, 5 interrupt reason, 6 sequence step, 7 FIFO flags, 8 configuration 1. Reads are combinational. Writes and read side effects take effect at the next rising clock edge.

Top module: `scsi_cmd_irq_unit`

## Requirements
- R1: `irq` equals status bit 7. Only a raising command or `phase_done` can set that bit. Raising the bit while it is already set changes nothing.
- R2: A read of address 5 returns the reason value held before the read. At that clock edge the read zeroes the reason register, clears status bit 4 (terminal count) and loads the step register with 4 (command done). It also drops `irq`.
- R3: A write to address 0 or 1 clears status bit 4. The value is stored as a pending count, and the readable count at that address does not change.
- R4: A command byte is bit 7 (DMA flag) plus bits 6:0 (opcode). A known command with the flag set drives `dma_mode` high and copies both pending counts into the readable counts. A known command without the flag drives `dma_mode` low.
- R5: Flush (0x01) sets reason to 0x08 (function complete) and zeroes step and flags. It leaves `irq` unchanged.
- R6: Bus reset (0x03) sets reason to 0x80. It raises the interrupt only when configuration-1 bit 6 (report suppress) is clear.
- R7: Message accepted (0x12) sets reason to 0x20, zeroes step and flags, and raises the interrupt. Disable selection (0x45) zeroes reason and raises the interrupt. Enable selection (0x44) zeroes reason and does not raise it.
- R8: Pad (0x18) sets status bits 6:0 to 0x10 and keeps bit 7. It sets reason to 0x08 and step to 0.
- R9: Complete sequence (0x11) sets reason to 0x08, sets phase bits 2:0 to 7 (message in) and raises the interrupt. With the DMA flag it also sets terminal count and step 4. Without the flag it sets flags to 2.
- R10: Transfer (0x10) with the DMA flag clears terminal count. NOP (0x00), set-attention (0x1A) and the select commands (0x41, 0x42, 0x43) change only the DMA state of R4.
- R11: A `phase_done` pulse sets reason to 0x18 (bus service plus function complete) and step to 4, and raises the interrupt.
- R12: Hard reset and the reset command (0x02) zero all registers and pending counts. They load the count-high register with `CHIP_ID` and configuration 1 with 7. `irq` and `dma_mode` go low.
- R13: Unknown opcodes leave all state unchanged. So do writes to addresses 2, 4 to 7 and 9 to 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (enables read side effects) |
| rd_data | output | 8 | Read data for the addressed register |
| phase_done | input | 1 | Single-cycle phase-completion event |
| irq | output | 1 | Level interrupt request |
| dma_mode | output | 1 | DMA mode chosen by the last known command |

## Verification
The checker watches every cycle for the following:
- the interrupt rising without a write or event in the cycle before;
- the acknowledge read leaving the interrupt or terminal count set;
- a count write leaving terminal count set;
- a flush changing the interrupt line;
- an unknown opcode disturbing any register;
- the state right after reset.

The exact reason, step, flag and phase values of each command, the reload of the readable counts, and the suppress bit's effect on bus reset are visible only in the bench's scenarios. The bench compares those against its own register model after every directed and random access.

// File: rtl/scsi_cu_pkg.sv
package scsi_cu_pkg;

    localparam int DW = 8;
    localparam int AW = 4;

    typedef enum logic [AW-1:0] {
        A_CNT_LO  = 4'h0,
        A_CNT_MID = 4'h1,
        A_CNT_HI  = 4'h2,
        A_CMD     = 4'h3,
        A_STAT    = 4'h4,
        A_REASON  = 4'h5,
        A_STEP    = 4'h6,
        A_FLAGS   = 4'h7,
        A_CFG1    = 4'h8
    } reg_addr_e;

    typedef enum logic [6:0] {
        OP_NOP       = 7'h00,
        OP_FLUSH     = 7'h01,
        OP_RESET     = 7'h02,
        OP_BUS_RESET = 7'h03,
        OP_XFER      = 7'h10,
        OP_CMPL_SEQ  = 7'h11,
        OP_MSG_ACC   = 7'h12,
        OP_PAD       = 7'h18,
        OP_SET_ATN   = 7'h1A,
        OP_SEL       = 7'h41,
        OP_SEL_ATN   = 7'h42,
        OP_SEL_STOP  = 7'h43,
        OP_EN_SEL    = 7'h44,
        OP_DIS_SEL   = 7'h45
    } opcode_e;

    localparam int ST_INT    = 7;
    localparam int ST_TC     = 4;
    localparam int CFG_NORPT = 6;

    localparam logic [DW-1:0] RSN_FC    = 8'h08;
    localparam logic [DW-1:0] RSN_BS    = 8'h10;
    localparam logic [DW-1:0] RSN_DC    = 8'h20;
    localparam logic [DW-1:0] RSN_BRST  = 8'h80;
    localparam logic [DW-1:0] STEP_DONE = 8'h04;
    localparam logic [DW-1:0] CFG1_INIT = 8'h07;
    localparam logic [2:0]    PH_MSGIN  = 3'd7;

    typedef enum logic [1:0] {
        IRQ_KEEP,
        IRQ_RAISE,
        IRQ_RAISE_RPT
    } irq_op_e;

    typedef struct packed {
        logic          known;
        logic          soft_rst;
        logic          ld_reason;
        logic [DW-1:0] reason;
        logic          ld_step;
        logic [DW-1:0] step;
        logic          ld_flags;
        logic [DW-1:0] flags;
        logic          st_tc_only;
        logic          set_tc;
        logic          clr_tc;
        logic          set_phase;
        logic [2:0]    phase;
        irq_op_e       irq_op;
    } cmd_act_t;

    typedef struct packed {
        logic [DW-1:0] stat;
        logic [DW-1:0] reason;
        logic [DW-1:0] step;
        logic [DW-1:0] flags;
        logic [DW-1:0] cfg1;
        logic [DW-1:0] cnt_lo;
        logic [DW-1:0] cnt_mid;
        logic [DW-1:0] cnt_hi;
        logic [DW-1:0] pend_lo;
        logic [DW-1:0] pend_mid;
        logic          dma;
    } regs_t;

    function automatic regs_t init_image(input logic [DW-1:0] chip_id);
        regs_t r;
        r        = '0;
        r.cnt_hi = chip_id;
        r.cfg1   = CFG1_INIT;
        return r;
    endfunction

    function automatic logic [DW-1:0] irq_set(input logic [DW-1:0] s);
        logic [DW-1:0] o;
        o         = s;
        o[ST_INT] = 1'b1;
        return o;
    endfunction

    function automatic logic [DW-1:0] irq_clr(input logic [DW-1:0] s);
        logic [DW-1:0] o;
        o         = s;
        o[ST_INT] = 1'b0;
        return o;
    endfunction

endpackage

// File: rtl/cu_cmd_decode.sv
module cu_cmd_decode
    import scsi_cu_pkg::*;
(
    input  logic [DW-1:0] cmd_byte,
    output cmd_act_t      act
);
    logic dma_flag;
    assign dma_flag = cmd_byte[DW-1];

    always_comb begin
        act       = '0;
        act.known = 1'b1;
        unique case (cmd_byte[6:0])
            OP_NOP, OP_SET_ATN, OP_SEL, OP_SEL_ATN, OP_SEL_STOP: ;
            OP_FLUSH: begin
                act.ld_reason = 1'b1; act.reason = RSN_FC;
                act.ld_step   = 1'b1; act.step   = '0;
                act.ld_flags  = 1'b1; act.flags  = '0;
            end
            OP_RESET: act.soft_rst = 1'b1;
            OP_BUS_RESET: begin
                act.ld_reason = 1'b1; act.reason = RSN_BRST;
                act.irq_op    = IRQ_RAISE_RPT;
            end
            OP_XFER: act.clr_tc = dma_flag;
            OP_CMPL_SEQ: begin
                act.ld_reason = 1'b1; act.reason = RSN_FC;
                act.set_phase = 1'b1; act.phase  = PH_MSGIN;
                act.irq_op    = IRQ_RAISE;
                if (dma_flag) begin
                    act.set_tc  = 1'b1;
                    act.ld_step = 1'b1; act.step = STEP_DONE;
                end else begin
                    act.ld_flags = 1'b1; act.flags = 8'h02;
                end
            end
            OP_MSG_ACC: begin
                act.ld_reason = 1'b1; act.reason = RSN_DC;
                act.ld_step   = 1'b1; act.step   = '0;
                act.ld_flags  = 1'b1; act.flags  = '0;
                act.irq_op    = IRQ_RAISE;
            end
            OP_PAD: begin
                act.st_tc_only = 1'b1;
                act.ld_reason  = 1'b1; act.reason = RSN_FC;
                act.ld_step    = 1'b1; act.step   = '0;
            end
            OP_EN_SEL: begin
                act.ld_reason = 1'b1; act.reason = '0;
            end
            OP_DIS_SEL: begin
                act.ld_reason = 1'b1; act.reason = '0;
                act.irq_op    = IRQ_RAISE;
            end
            default: act.known = 1'b0;
        endcase
    end
endmodule

// File: rtl/cu_regs.sv
module cu_regs
    import scsi_cu_pkg::*;
#(
    parameter logic [DW-1:0] CHIP_ID = 8'hA2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cnt_lo_wr,
    input  logic          cnt_mid_wr,
    input  logic          cfg_wr,
    input  logic          cmd_wr,
    input  logic [DW-1:0] wdata,
    input  cmd_act_t      act,
    input  logic          ack_rd,
    input  logic          evt,
    output regs_t         regs
);
    regs_t cur, nxt;
    logic  dma_flag;

    assign dma_flag = wdata[DW-1];
    assign regs     = cur;

    always_comb begin
        nxt = cur;
        if (ack_rd) begin
            nxt.reason       = '0;
            nxt.stat[ST_TC]  = 1'b0;
            nxt.step         = STEP_DONE;
            nxt.stat         = irq_clr(nxt.stat);
        end
        if (evt) begin
            nxt.reason = RSN_BS | RSN_FC;
            nxt.step   = STEP_DONE;
            nxt.stat   = irq_set(nxt.stat);
        end
        if (cnt_lo_wr) begin
            nxt.pend_lo     = wdata;
            nxt.stat[ST_TC] = 1'b0;
        end
        if (cnt_mid_wr) begin
            nxt.pend_mid    = wdata;
            nxt.stat[ST_TC] = 1'b0;
        end
        if (cfg_wr)
            nxt.cfg1 = wdata;
        if (cmd_wr && act.known) begin
            if (act.soft_rst) begin
                nxt = init_image(CHIP_ID);
            end else begin
                nxt.dma = dma_flag;
                if (dma_flag) begin
                    nxt.cnt_lo  = nxt.pend_lo;
                    nxt.cnt_mid = nxt.pend_mid;
                end
                if (act.ld_reason)  nxt.reason = act.reason;
                if (act.ld_step)    nxt.step   = act.step;
                if (act.ld_flags)   nxt.flags  = act.flags;
                if (act.st_tc_only) nxt.stat   = {nxt.stat[ST_INT], 7'h10};
                if (act.set_tc)     nxt.stat[ST_TC] = 1'b1;
                if (act.clr_tc)     nxt.stat[ST_TC] = 1'b0;
                if (act.set_phase)  nxt.stat[2:0]   = act.phase;
                unique case (act.irq_op)
                    IRQ_RAISE:     nxt.stat = irq_set(nxt.stat);
                    IRQ_RAISE_RPT: if (!nxt.cfg1[CFG_NORPT]) nxt.stat = irq_set(nxt.stat);
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= init_image(CHIP_ID);
        else     cur <= nxt;
    end
endmodule

// File: rtl/scsi_cmd_irq_unit.sv
module scsi_cmd_irq_unit
    import scsi_cu_pkg::*;
#(
    parameter logic [DW-1:0] CHIP_ID = 8'hA2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          phase_done,
    output logic          irq,
    output logic          dma_mode
);
    cmd_act_t act;
    regs_t    regs_q;

    cu_cmd_decode u_dec (
        .cmd_byte (wr_data),
        .act      (act)
    );

    cu_regs #(.CHIP_ID(CHIP_ID)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cnt_lo_wr  (wr_en && addr == A_CNT_LO),
        .cnt_mid_wr (wr_en && addr == A_CNT_MID),
        .cfg_wr     (wr_en && addr == A_CFG1),
        .cmd_wr     (wr_en && addr == A_CMD),
        .wdata      (wr_data),
        .act        (act),
        .ack_rd     (rd_en && addr == A_REASON),
        .evt        (phase_done),
        .regs       (regs_q)
    );

    always_comb begin
        unique case (addr)
            A_CNT_LO:  rd_data = regs_q.cnt_lo;
            A_CNT_MID: rd_data = regs_q.cnt_mid;
            A_CNT_HI:  rd_data = regs_q.cnt_hi;
            A_STAT:    rd_data = regs_q.stat;
            A_REASON:  rd_data = regs_q.reason;
            A_STEP:    rd_data = regs_q.step;
            A_FLAGS:   rd_data = regs_q.flags;
            A_CFG1:    rd_data = regs_q.cfg1;
            default:   rd_data = '0;
        endcase
    end

    assign irq      = regs_q.stat[ST_INT];
    assign dma_mode = regs_q.dma;
endmodule

// File: rtl/cu_sva_checker.sv
module cu_sva_checker
    import scsi_cu_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] addr,
    input logic          wr_en,
    input logic [6:0]    opcode,
    input logic          rd_en,
    input logic          phase_done,
    input logic          irq,
    input logic          cmd_known,
    input regs_t         regs
);
    logic quiet_wr, ack;
    assign quiet_wr = wr_en && !rd_en && !phase_done;
    assign ack      = rd_en && addr == A_REASON && !wr_en && !phase_done;

    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(wr_en || phase_done)); // R1

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ack |=> (!irq && regs.reason == '0 && regs.step == STEP_DONE && !regs.stat[ST_TC])); // R2

    AST_CNT_WR_CLEARS_TC: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == A_CNT_LO || addr == A_CNT_MID)) |=> !regs.stat[ST_TC]); // R3

    AST_FLUSH_KEEPS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (quiet_wr && addr == A_CMD && opcode == OP_FLUSH) |=> (irq == $past(irq) && regs.reason == RSN_FC)); // R5

    AST_RESET_IMAGE: assert property (@(posedge clk)
        rst |=> (!irq && regs.cfg1 == CFG1_INIT && regs.reason == '0 && !regs.dma)); // R12

    AST_UNKNOWN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (quiet_wr && addr == A_CMD && !cmd_known) |=> $stable(regs)); // R13
endmodule

bind scsi_cmd_irq_unit cu_sva_checker u_sva (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .wr_en      (wr_en),
    .opcode     (wr_data[6:0]),
    .rd_en      (rd_en),
    .phase_done (phase_done),
    .irq        (irq),
    .cmd_known  (act.known),
    .regs       (regs_q)
);

// File: tb/sim_scsi_cmd_irq_unit.sv
module sim_scsi_cmd_irq_unit;
    localparam logic [7:0] CHIP = 8'hA2;

    logic       clk = 0, rst = 1;
    logic [3:0] addr = 0;
    logic       wr_en = 0, rd_en = 0, phase_done = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       irq, dma_mode;

    int n_chk = 0, n_err = 0;

    logic [7:0] m_stat, m_reason, m_step, m_flags, m_cfg1, m_lo, m_mid, m_plo, m_pmid;
    logic       m_dma;

    always #4 clk = ~clk;

    scsi_cmd_irq_unit #(.CHIP_ID(CHIP)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .phase_done(phase_done),
        .irq(irq), .dma_mode(dma_mode));

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic m_reset();
        m_stat = 0; m_reason = 0; m_step = 0; m_flags = 0; m_cfg1 = 8'h07;
        m_lo = 0; m_mid = 0; m_plo = 0; m_pmid = 0; m_dma = 0;
    endtask

    task automatic m_cmd(input logic [7:0] c);
        logic [6:0] op;
        op = c[6:0];
        case (op)
            7'h00, 7'h01, 7'h02, 7'h03, 7'h10, 7'h11, 7'h12, 7'h18,
            7'h1A, 7'h41, 7'h42, 7'h43, 7'h44, 7'h45: ;
            default: return;
        endcase
        if (op == 7'h02) begin m_reset(); return; end
        m_dma = c[7];
        if (c[7]) begin m_lo = m_plo; m_mid = m_pmid; end
        case (op)
            7'h01: begin m_reason = 8'h08; m_step = 0; m_flags = 0; end
            7'h03: begin m_reason = 8'h80; if (!m_cfg1[6]) m_stat[7] = 1; end
            7'h10: if (c[7]) m_stat[4] = 0;
            7'h11: begin
                m_reason = 8'h08; m_stat[2:0] = 3'd7; m_stat[7] = 1;
                if (c[7]) begin m_stat[4] = 1; m_step = 8'h04; end
                else m_flags = 8'h02;
            end
            7'h12: begin m_reason = 8'h20; m_step = 0; m_flags = 0; m_stat[7] = 1; end
            7'h18: begin m_stat = {m_stat[7], 7'h10}; m_reason = 8'h08; m_step = 0; end
            7'h44: m_reason = 0;
            7'h45: begin m_reason = 0; m_stat[7] = 1; end
            default: ;
        endcase
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wr_data = d; wr_en = 1;
        @(negedge clk); wr_en = 0;
        case (a)
            4'h0: begin m_plo = d; m_stat[4] = 0; end
            4'h1: begin m_pmid = d; m_stat[4] = 0; end
            4'h3: m_cmd(d);
            4'h8: m_cfg1 = d;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; rd_en = 1;
        #1 v = rd_data;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic ack(input string tag);
        logic [7:0] v;
        rd(4'h5, v);
        chk(v === m_reason, tag, "reason read value", v, m_reason);
        m_reason = 0; m_stat[4] = 0; m_step = 8'h04; m_stat[7] = 0;
    endtask

    task automatic pulse();
        @(negedge clk); phase_done = 1;
        @(negedge clk); phase_done = 0;
        m_reason = 8'h18; m_step = 8'h04; m_stat[7] = 1;
    endtask

    task automatic check_all(input string tag);
        logic [7:0] v;
        chk(irq === m_stat[7], tag, "irq", {7'd0, irq}, {7'd0, m_stat[7]});
        chk(dma_mode === m_dma, tag, "dma_mode", {7'd0, dma_mode}, {7'd0, m_dma});
        rd(4'h4, v); chk(v === m_stat,  tag, "status", v, m_stat);
        rd(4'h6, v); chk(v === m_step,  tag, "step",   v, m_step);
        rd(4'h7, v); chk(v === m_flags, tag, "flags",  v, m_flags);
        rd(4'h8, v); chk(v === m_cfg1,  tag, "cfg1",   v, m_cfg1);
        rd(4'h0, v); chk(v === m_lo,    tag, "cnt_lo", v, m_lo);
        rd(4'h1, v); chk(v === m_mid,   tag, "cnt_mid", v, m_mid);
        rd(4'h2, v); chk(v === CHIP,    tag, "cnt_hi", v, CHIP);
    endtask

    initial begin
        #(8 * 190000);
        n_err++; n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [6:0] ops [14];
        ops = '{7'h00, 7'h01, 7'h02, 7'h03, 7'h10, 7'h11, 7'h12,
                7'h18, 7'h1A, 7'h41, 7'h42, 7'h43, 7'h44, 7'h45};
        void'($urandom(32'd5150));
        m_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        check_all("R12 hard reset");

        wr(4'h0, 8'h34); wr(4'h1, 8'h12);
        check_all("R3 pending counts not visible");
        wr(4'h3, 8'h80);
        check_all("R4 dma reload");
        wr(4'h3, 8'h00);
        check_all("R4 dma off");

        wr(4'h3, 8'h91);
        chk(irq === 1'b1, "R9", "irq after dma complete-seq", {7'd0, irq}, 8'h01);
        check_all("R9 complete seq dma");
        ack("R2");
        chk(irq === 1'b0, "R2", "irq after ack", {7'd0, irq}, 8'h00);
        check_all("R2 ack side effects");
        wr(4'h3, 8'h11);
        check_all("R9 complete seq pio");
        ack("R2");

        wr(4'h3, 8'h12);
        check_all("R7 msg accepted");
        wr(4'h3, 8'h45);
        check_all("R1 redundant raise");
        ack("R7");
        wr(4'h3, 8'h44);
        check_all("R7 enable sel");

        wr(4'h8, 8'h47); wr(4'h3, 8'h03);
        chk(irq === 1'b0, "R6", "irq with suppress", {7'd0, irq}, 8'h00);
        check_all("R6 suppressed");
        wr(4'h8, 8'h07); wr(4'h3, 8'h03);
        check_all("R6 reported");
        ack("R6");

        wr(4'h3, 8'h01);
        check_all("R5 flush irq low");
        wr(4'h3, 8'h18);
        check_all("R8 pad");
        wr(4'h3, 8'h10);
        check_all("R10 transfer pio keeps tc");
        wr(4'h3, 8'h90);
        check_all("R10 transfer dma clears tc");
        wr(4'h3, 8'h18); wr(4'h1, 8'h55);
        check_all("R3 count write clears tc");
        wr(4'h3, 8'hC2); wr(4'h3, 8'h1A);
        check_all("R10 select/atn no effect");

        pulse();
        check_all("R11 phase done");
        wr(4'h3, 8'h7F); wr(4'h3, 8'hA0); wr(4'hF, 8'hFF); wr(4'h4, 8'h00); wr(4'h2, 8'h00);
        check_all("R13 ignored writes");
        wr(4'h3, 8'h02);
        check_all("R12 soft reset");

        for (int i = 0; i < 2500; i++) begin
            int k;
            k = $urandom % 10;
            case (k)
                0, 1, 2, 3: begin
                    logic [7:0] c;
                    c[6:0] = ($urandom % 8 == 0) ? 7'($urandom) : ops[$urandom % 14];
                    c[7]   = 1'($urandom);
                    wr(4'h3, c);
                end
                4: wr(4'($urandom % 2), 8'($urandom));
                5: ack("R2 random");
                6: pulse();
                7: wr(4'h8, 8'($urandom));
                8: wr(4'($urandom % 2 == 0 ? 9 + $urandom % 7 : 4 + $urandom % 4), 8'($urandom));
                default: ;
            endcase
            check_all("R1/R13 random");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule